// File: doc/BRIEF.md
# Local-History Two-Level Branch Predictor

This block sits beside the fetch address of a wide in-order front end. Every cycle it looks up the current fetch address in a table of branch entries. Each entry holds four things: a tag, the branch's own recent outcome history, a private set of two-bit saturating counters selected by that history, and the last resolved target. When the entry hits and the selected counter points to taken, the stored target becomes the next fetch address in the same cycle, so no address arithmetic is needed. Otherwise the block returns the sequential bundle-pair address.

The back end reports resolved branches on up to three update slots per cycle. Each slot carries the branch's bundle-pair number, its real direction and its real target. A separate resteer input carries the corrected fetch address after a misprediction, and it overrides any prediction in the cycle it is raised. Only resolved outcomes change the tables. An update changes what lookups see from the next cycle on.

Top module: `bp_local_predictor`

## Requirements
- R1: After reset every entry is empty, so each lookup reports pred_hit=0 and pred_taken=0.
- R2: A lookup that misses returns pred_taken=0 and next_addr = fetch_addr + 32 (one bundle pair). A lookup hits when the entry at index fetch_addr[8:5] is valid and its tag equals fetch_addr[31:9].
- R3: The prediction is a combinational function of fetch_addr and the table. An update written at a clock edge is visible to lookups from the following cycle on. A lookup in the update's own cycle sees the old state.
- R4: An update whose entry misses allocates that entry. The new entry starts with history 0000 and all counters at 01 (weakly not-taken), and the update's outcome is then applied to it.
- R5: Each counter moves up on taken and down on not-taken, and it holds at 3 and at 0. A hit predicts taken exactly when bit 1 of the counter selected by the entry's history is set.
- R6: An update shifts the 4-bit history left and inserts the outcome at bit 0 (1 means taken). The counter for the update is chosen by the history before the shift.
- R7: A taken prediction returns the target written by the most recent update of that entry. Every update writes its target, whatever its direction.
- R8: When resteer_valid is 1, next_addr equals resteer_addr, whatever the prediction.
- R9: Several slots that update the same entry in one cycle are applied in slot order, slot 0 first. Each slot sees the history, counters and target left by the slots before it.
- R10: An update to a branch whose index matches a valid entry with a different tag replaces that entry, and the old branch then misses.
- R11: Slots that update different entries in one cycle all take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fetch_addr | input | 32 | Byte address of the current fetch bundle pair |
| resteer_valid | input | 1 | Back-end correction present this cycle |
| resteer_addr | input | 32 | Corrected next fetch address |
| upd_valid | input | 3 | One valid bit per resolution slot |
| upd_pair | input | 81 | Per slot, bundle-pair number of the branch (byte address >> 5), slot k at [27k+26:27k] |
| upd_taken | input | 3 | Per slot, resolved direction (1 = taken) |
| upd_target | input | 96 | Per slot, resolved target address, slot k at [32k+31:32k] |
| pred_hit | output | 1 | Lookup found a matching entry |
| pred_taken | output | 1 | Lookup predicts taken |
| next_addr | output | 32 | Predicted or corrected next fetch address |

## Verification
The assertions assume that fetch_addr, resteer and the update slots are held steady across each clock edge and are known after reset. They also assume that an update in slot 0 alone is never disturbed by another slot that aims at the same index in that cycle. The bench drives every input on the falling edge and keeps each update pattern to either one slot, several slots on one branch, or slots on distinct indices. That keeps the slot-0 visibility property meaningful. Idle cycles with a fixed fetch address are inserted so that the hold-still property sees no table change.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_WEAK_NT = 2'b01;

  function automatic ctr_t ctr_step(input ctr_t c, input logic taken);
    ctr_t r;
    if (taken) r = (c == 2'b11) ? c : c + 2'd1;
    else       r = (c == 2'b00) ? c : c - 2'd1;
    return r;
  endfunction
endpackage

// File: rtl/bp_reset_sync.sv
module bp_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/bp_entry.sv
module bp_entry
  import bp_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int OFF_W    = 5,
  parameter int IDX_W    = 4,
  parameter int TAG_W    = 23,
  parameter int PAIR_W   = 27,
  parameter int HIST_W   = 4,
  parameter int CNT      = 16,
  parameter int SLOTS    = 3,
  parameter int ENTRY_ID = 0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [SLOTS-1:0]         upd_valid,
  input  logic [SLOTS*PAIR_W-1:0]  upd_pair,
  input  logic [SLOTS-1:0]         upd_taken,
  input  logic [SLOTS*ADDR_W-1:0]  upd_target,
  output logic                     valid_o,
  output logic [TAG_W-1:0]         tag_o,
  output logic [HIST_W-1:0]        hist_o,
  output logic [CNT*2-1:0]         ctr_o,
  output logic [ADDR_W-1:0]        tgt_o
);
  localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(ENTRY_ID);

  logic                      valid_q, valid_d;
  logic [TAG_W-1:0]          tag_q, tag_d;
  logic [HIST_W-1:0]         hist_q, hist_d;
  logic [CNT-1:0][1:0]       ctr_q, ctr_d;
  logic [ADDR_W-1:0]         tgt_q, tgt_d;
  logic                      load_en;

  // Slots are folded in order: slot k sees the result of slots 0..k-1.
  always_comb begin
    valid_d = valid_q;
    tag_d   = tag_q;
    hist_d  = hist_q;
    ctr_d   = ctr_q;
    tgt_d   = tgt_q;
    load_en = 1'b0;
    for (int k = 0; k < SLOTS; k++) begin
      if (upd_valid[k] && (upd_pair[k*PAIR_W +: IDX_W] == MY_IDX)) begin
        load_en = 1'b1;
        if (!valid_d || (tag_d != upd_pair[k*PAIR_W+IDX_W +: TAG_W])) begin
          valid_d = 1'b1;
          tag_d   = upd_pair[k*PAIR_W+IDX_W +: TAG_W];
          hist_d  = '0;
          for (int j = 0; j < CNT; j++) ctr_d[j] = CTR_WEAK_NT;
        end
        ctr_d[hist_d] = ctr_step(ctr_d[hist_d], upd_taken[k]);
        hist_d        = {hist_d[HIST_W-2:0], upd_taken[k]};
        tgt_d         = upd_target[k*ADDR_W +: ADDR_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       valid_q <= 1'b0;
    else if (load_en) valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (load_en) begin
      tag_q  <= tag_d;
      hist_q <= hist_d;
      ctr_q  <= ctr_d;
      tgt_q  <= tgt_d;
    end
  end

  assign valid_o = valid_q;
  assign tag_o   = tag_q;
  assign hist_o  = hist_q;
  assign ctr_o   = ctr_q;
  assign tgt_o   = tgt_q;
endmodule

// File: rtl/bp_lookup.sv
module bp_lookup #(
  parameter int ADDR_W       = 32,
  parameter int OFF_W        = 5,
  parameter int IDX_W        = 4,
  parameter int TAG_W        = 23,
  parameter int HIST_W       = 4,
  parameter int CNT          = 16,
  parameter int ENTRIES      = 16,
  parameter int BUNDLE_BYTES = 32
) (
  input  logic [ADDR_W-1:0]          fetch_addr,
  input  logic                       resteer_valid,
  input  logic [ADDR_W-1:0]          resteer_addr,
  input  logic [ENTRIES-1:0]         ent_valid,
  input  logic [ENTRIES*TAG_W-1:0]   ent_tag,
  input  logic [ENTRIES*HIST_W-1:0]  ent_hist,
  input  logic [ENTRIES*CNT*2-1:0]   ent_ctr,
  input  logic [ENTRIES*ADDR_W-1:0]  ent_tgt,
  output logic                       pred_hit,
  output logic                       pred_taken,
  output logic [ADDR_W-1:0]          next_addr
);
  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  sel_tag;
  logic [HIST_W-1:0] sel_hist;
  logic [1:0]        sel_ctr;
  logic [ADDR_W-1:0] sel_tgt;
  logic [ADDR_W-1:0] seq_addr;

  always_comb begin
    idx      = fetch_addr[OFF_W +: IDX_W];
    sel_tag  = ent_tag[int'(idx)*TAG_W +: TAG_W];
    sel_hist = ent_hist[int'(idx)*HIST_W +: HIST_W];
    sel_ctr  = ent_ctr[(int'(idx)*CNT + int'(sel_hist))*2 +: 2];
    sel_tgt  = ent_tgt[int'(idx)*ADDR_W +: ADDR_W];
    seq_addr = fetch_addr + ADDR_W'(BUNDLE_BYTES);

    pred_hit   = ent_valid[idx] && (sel_tag == fetch_addr[OFF_W+IDX_W +: TAG_W]);
    pred_taken = pred_hit && sel_ctr[1];

    if (resteer_valid)   next_addr = resteer_addr;
    else if (pred_taken) next_addr = sel_tgt;
    else                 next_addr = seq_addr;
  end
endmodule

// File: rtl/bp_local_predictor.sv
module bp_local_predictor #(
  parameter int ADDR_W       = 32,
  parameter int ENTRIES      = 16,
  parameter int HIST_W       = 4,
  parameter int SLOTS        = 3,
  parameter int BUNDLE_BYTES = 32,
  parameter int OFF_W        = $clog2(BUNDLE_BYTES),
  parameter int PAIR_W       = ADDR_W - OFF_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        fetch_addr,
  input  logic                     resteer_valid,
  input  logic [ADDR_W-1:0]        resteer_addr,
  input  logic [SLOTS-1:0]         upd_valid,
  input  logic [SLOTS*PAIR_W-1:0]  upd_pair,
  input  logic [SLOTS-1:0]         upd_taken,
  input  logic [SLOTS*ADDR_W-1:0]  upd_target,
  output logic                     pred_hit,
  output logic                     pred_taken,
  output logic [ADDR_W-1:0]        next_addr
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = PAIR_W - IDX_W;
  localparam int CNT   = 1 << HIST_W;

  logic                      rst_sync_n;
  logic [ENTRIES-1:0]        ent_valid;
  logic [ENTRIES*TAG_W-1:0]  ent_tag;
  logic [ENTRIES*HIST_W-1:0] ent_hist;
  logic [ENTRIES*CNT*2-1:0]  ent_ctr;
  logic [ENTRIES*ADDR_W-1:0] ent_tgt;

  bp_reset_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    bp_entry #(
      .ADDR_W   (ADDR_W),
      .OFF_W    (OFF_W),
      .IDX_W    (IDX_W),
      .TAG_W    (TAG_W),
      .PAIR_W   (PAIR_W),
      .HIST_W   (HIST_W),
      .CNT      (CNT),
      .SLOTS    (SLOTS),
      .ENTRY_ID (e)
    ) u_ent (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .upd_valid  (upd_valid),
      .upd_pair   (upd_pair),
      .upd_taken  (upd_taken),
      .upd_target (upd_target),
      .valid_o    (ent_valid[e]),
      .tag_o      (ent_tag[e*TAG_W +: TAG_W]),
      .hist_o     (ent_hist[e*HIST_W +: HIST_W]),
      .ctr_o      (ent_ctr[e*CNT*2 +: CNT*2]),
      .tgt_o      (ent_tgt[e*ADDR_W +: ADDR_W])
    );
  end

  bp_lookup #(
    .ADDR_W       (ADDR_W),
    .OFF_W        (OFF_W),
    .IDX_W        (IDX_W),
    .TAG_W        (TAG_W),
    .HIST_W       (HIST_W),
    .CNT          (CNT),
    .ENTRIES      (ENTRIES),
    .BUNDLE_BYTES (BUNDLE_BYTES)
  ) u_look (
    .fetch_addr    (fetch_addr),
    .resteer_valid (resteer_valid),
    .resteer_addr  (resteer_addr),
    .ent_valid     (ent_valid),
    .ent_tag       (ent_tag),
    .ent_hist      (ent_hist),
    .ent_ctr       (ent_ctr),
    .ent_tgt       (ent_tgt),
    .pred_hit      (pred_hit),
    .pred_taken    (pred_taken),
    .next_addr     (next_addr)
  );
endmodule

// File: rtl/bp_local_predictor_checker.sv
module bp_local_predictor_checker #(
  parameter int ADDR_W       = 32,
  parameter int OFF_W        = 5,
  parameter int SLOTS        = 3,
  parameter int BUNDLE_BYTES = 32,
  parameter int PAIR_W       = ADDR_W - OFF_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic              resteer_valid,
  input logic [ADDR_W-1:0] resteer_addr,
  input logic [SLOTS-1:0]  upd_valid,
  input logic [PAIR_W-1:0] upd_pair0,
  input logic              pred_hit,
  input logic              pred_taken,
  input logic [ADDR_W-1:0] next_addr
);
  localparam logic [SLOTS-1:0] ONLY_SLOT0 = SLOTS'(1);

  assert_resteer_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    resteer_valid |-> (next_addr == resteer_addr));

  assert_miss_sequential_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!resteer_valid && !pred_hit) |->
      (!pred_taken && next_addr == fetch_addr + ADDR_W'(BUNDLE_BYTES)));

  // R5: a not-taken prediction always falls through to the next bundle pair
  assert_not_taken_falls_through_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!resteer_valid && !pred_taken) |-> (next_addr == fetch_addr + ADDR_W'(BUNDLE_BYTES)));

  assert_alloc_visible_next_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid == ONLY_SLOT0) |=>
      ((fetch_addr[ADDR_W-1:OFF_W] != $past(upd_pair0)) || pred_hit));

  assert_idle_prediction_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid == '0) |=> (!$stable(fetch_addr) || ($stable(pred_taken) && $stable(pred_hit))));
endmodule

bind bp_local_predictor bp_local_predictor_checker #(
  .ADDR_W       (ADDR_W),
  .OFF_W        (OFF_W),
  .SLOTS        (SLOTS),
  .BUNDLE_BYTES (BUNDLE_BYTES)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .fetch_addr    (fetch_addr),
  .resteer_valid (resteer_valid),
  .resteer_addr  (resteer_addr),
  .upd_valid     (upd_valid),
  .upd_pair0     (upd_pair[PAIR_W-1:0]),
  .pred_hit      (pred_hit),
  .pred_taken    (pred_taken),
  .next_addr     (next_addr)
);

// File: tb/bp_local_predictor_test.sv
module bp_local_predictor_test;
  localparam int AW = 32;
  localparam int SL = 3;
  localparam int PW = 27;

  logic            clk;
  logic            rst_n;
  logic [AW-1:0]   fetch_addr;
  logic            resteer_valid;
  logic [AW-1:0]   resteer_addr;
  logic [SL-1:0]   upd_valid;
  logic [SL*PW-1:0] upd_pair;
  logic [SL-1:0]   upd_taken;
  logic [SL*AW-1:0] upd_target;
  logic            pred_hit;
  logic            pred_taken;
  logic [AW-1:0]   next_addr;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  bp_local_predictor uut (
    .clk(clk), .rst_n(rst_n), .fetch_addr(fetch_addr),
    .resteer_valid(resteer_valid), .resteer_addr(resteer_addr),
    .upd_valid(upd_valid), .upd_pair(upd_pair), .upd_taken(upd_taken),
    .upd_target(upd_target), .pred_hit(pred_hit), .pred_taken(pred_taken),
    .next_addr(next_addr)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // row: upd_v, upd_taken, upd_addr, upd_tgt, fetch, exp_hit, exp_taken, exp_next
  localparam int ROWS = 18;
  localparam logic [131:0] VEC [ROWS] = '{
    {1'b1,1'b1,32'h1000,32'h4000,32'h1000,1'b0,1'b0,32'h1020},  // alloc, miss
    {1'b1,1'b1,32'h1000,32'h4000,32'h1000,1'b1,1'b0,32'h1020},
    {1'b1,1'b1,32'h1000,32'h4000,32'h1000,1'b1,1'b0,32'h1020},
    {1'b1,1'b1,32'h1000,32'h4000,32'h1000,1'b1,1'b0,32'h1020},
    {1'b1,1'b1,32'h1000,32'h4000,32'h1000,1'b1,1'b0,32'h1020},
    {1'b1,1'b1,32'h1000,32'h4000,32'h1000,1'b1,1'b1,32'h4000},  // first taken
    {1'b1,1'b1,32'h1000,32'h4000,32'h1000,1'b1,1'b1,32'h4000},  // 11 holds
    {1'b1,1'b0,32'h1000,32'h4000,32'h1000,1'b1,1'b1,32'h4000},
    {1'b0,1'b0,32'h1000,32'h4000,32'h1000,1'b1,1'b0,32'h1020},  // hist 1110
    {1'b1,1'b1,32'h1000,32'h4000,32'h1000,1'b1,1'b0,32'h1020},
    {1'b1,1'b1,32'h1000,32'h4000,32'h1000,1'b1,1'b0,32'h1020},
    {1'b1,1'b1,32'h1000,32'h4000,32'h1000,1'b1,1'b0,32'h1020},
    {1'b1,1'b1,32'h1000,32'h4000,32'h1000,1'b1,1'b1,32'h4000},  // hist 0111
    {1'b0,1'b0,32'h1000,32'h4000,32'h1000,1'b1,1'b1,32'h4000},
    {1'b1,1'b0,32'h2020,32'h9000,32'h2020,1'b0,1'b0,32'h2040},  // alloc NT
    {1'b1,1'b0,32'h2020,32'h9000,32'h2020,1'b1,1'b0,32'h2040},
    {1'b1,1'b0,32'h2020,32'h9000,32'h2020,1'b1,1'b0,32'h2040},
    {1'b0,1'b0,32'h2020,32'h9000,32'h2020,1'b1,1'b0,32'h2040}   // 00 holds
  };

  task automatic check(input string req, input logic hit, input logic tk,
                       input logic [AW-1:0] nxt);
    checks++;
    if (pred_hit !== hit || pred_taken !== tk || next_addr !== nxt) begin
      errors++;
      $display("FAIL %s: got hit=%0b taken=%0b next=%h, expected hit=%0b taken=%0b next=%h",
               req, pred_hit, pred_taken, next_addr, hit, tk, nxt);
    end
  endtask

  task automatic idle_inputs();
    upd_valid = '0; upd_pair = '0; upd_taken = '0; upd_target = '0;
    resteer_valid = 1'b0; resteer_addr = '0;
  endtask

  task automatic set_slot(input int k, input logic [AW-1:0] a, input logic tk,
                          input logic [AW-1:0] tgt);
    upd_valid[k]             = 1'b1;
    upd_pair[k*PW +: PW]     = a[AW-1:5];
    upd_taken[k]             = tk;
    upd_target[k*AW +: AW]   = tgt;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    idle_inputs();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got no completion, expected completion");
      report();
    end
  end

  initial begin
    rst_n = 1'b0;
    fetch_addr = 32'h1000;
    idle_inputs();
    do_reset();

    // R1: empty after reset
    #1 check("R1 reset empty", 1'b0, 1'b0, 32'h1020);

    // Vector walk: R3 (old state seen in update cycle), R4, R5, R6, R7, R2
    for (int i = 0; i < ROWS; i++) begin
      @(negedge clk);
      idle_inputs();
      if (VEC[i][131]) set_slot(0, VEC[i][129:98], VEC[i][130], VEC[i][97:66]);
      fetch_addr = VEC[i][65:34];
      #1 check($sformatf("R3/R4/R5/R6/R7 row %0d", i),
               VEC[i][33], VEC[i][32], VEC[i][31:0]);
    end

    // R8: resteer overrides a taken prediction and a miss
    @(negedge clk); idle_inputs();
    fetch_addr = 32'h1000; resteer_valid = 1'b1; resteer_addr = 32'h8000;
    #1 check("R8 resteer over taken", 1'b1, 1'b1, 32'h8000);
    @(negedge clk);
    fetch_addr = 32'h7000; resteer_valid = 1'b1; resteer_addr = 32'h8040;
    #1 check("R8 resteer over miss", 1'b0, 1'b0, 32'h8040);

    // R10: same index, other tag misses, then replaces
    @(negedge clk); idle_inputs(); fetch_addr = 32'h1200;
    #1 check("R10 tag mismatch miss", 1'b0, 1'b0, 32'h1220);
    @(negedge clk); set_slot(0, 32'h1200, 1'b1, 32'hA000);
    @(negedge clk); idle_inputs(); fetch_addr = 32'h1000;
    #1 check("R10 old branch evicted", 1'b0, 1'b0, 32'h1020);
    @(negedge clk); fetch_addr = 32'h1200;
    #1 check("R10 new branch present", 1'b1, 1'b0, 32'h1220);

    // R9: three slots on one branch, two cycles, applied in slot order
    @(negedge clk); idle_inputs(); fetch_addr = 32'h0;
    set_slot(0, 32'h3040, 1'b1, 32'h5000);
    set_slot(1, 32'h3040, 1'b1, 32'h6000);
    set_slot(2, 32'h3040, 1'b1, 32'h7000);
    @(negedge clk); idle_inputs();
    set_slot(0, 32'h3040, 1'b1, 32'h5100);
    set_slot(1, 32'h3040, 1'b1, 32'h6100);
    set_slot(2, 32'h3040, 1'b1, 32'h7100);
    @(negedge clk); idle_inputs(); fetch_addr = 32'h3040;
    #1 check("R9 ordered slots", 1'b1, 1'b1, 32'h7100);

    // R11: distinct entries updated in one cycle
    @(negedge clk); idle_inputs(); fetch_addr = 32'h0;
    set_slot(0, 32'h40a0, 1'b1, 32'hB000);
    set_slot(2, 32'h50c0, 1'b0, 32'hC000);
    @(negedge clk); idle_inputs(); fetch_addr = 32'h40a0;
    #1 check("R11 slot0 entry", 1'b1, 1'b0, 32'h40c0);
    @(negedge clk); fetch_addr = 32'h50c0;
    #1 check("R11 slot2 entry", 1'b1, 1'b0, 32'h50e0);

    // R1: a second reset empties populated entries
    do_reset();
    fetch_addr = 32'h3040;
    #1 check("R1 reset clears taken entry", 1'b0, 1'b0, 32'h3060);
    @(negedge clk); fetch_addr = 32'h2020;
    #1 check("R1 reset clears other entry", 1'b0, 1'b0, 32'h2040);

    done = 1'b1;
    report();
  end
endmodule